// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer execution unit of a 32-bit processor pipeline. Each cycle it takes an operation code and two operands and produces a result with a write-enable. The result is combinational. It also keeps a small registered status word made of a carry bit, a condition flag and an overflow bit. The status word is read back into the same unit: add-with-carry reads the carry bit, and conditional move reads the condition flag.

The unit covers:
- add, add-with-carry and subtract;
- bitwise AND, OR and XOR;
- multiply;
- signed and unsigned divide;
- the three shifts;
- building an upper-half constant;
- byte and halfword extension;
- conditional select;
- locating the lowest set bit;
- ten compare operations.

The compare operations write only the condition flag. A zero divisor, or an undefined operation code, produces no result write and no status change. Instead it raises an illegal-operation strobe for the exception logic outside the block.

The result is meaningful only while `result_we` is high. The status word changes on the rising clock edge that ends an accepted operation (`op_valid` high and no illegal strobe). A parameter chooses whether add, add-with-carry and AND also write the condition flag with a zero test.

Top module: `int_alu_unit`

## Requirements
- R1: ADD (code 0) writes a+b modulo 2^32. Carry is set when that sum is unsigned-below operand A and cleared otherwise. Overflow is set when the signed sum does not fit in 32 bits.
- R2: ADDC (code 1) writes a+b+carry modulo 2^32 and uses the same carry rule as ADD: the sum must be unsigned-below A. So A plus 0xFFFFFFFF plus a carry of 1 leaves carry at 0. Overflow follows the signed sum of all three terms.
- R3: SUB (code 2) writes a-b and sets overflow when the signed difference does not fit. Only ADD and ADDC ever change the carry bit.
- R4: With ARITH_FLAG_EN=1 (the default), ADD, ADDC and AND (code 3) set the condition flag exactly when their result is zero. All other result-writing operations leave the flag unchanged.
- R5: OR (code 4), XOR (code 5) and MUL (code 6) write a|b, a^b and the low 32 bits of a*b.
- R6: SLL (code 9), SRL (code 10) and SRA (code 11) shift A by the low 5 bits of B. The first two fill with zeros; SRA copies A's sign bit.
- R7: DIV (code 7) writes the signed quotient truncated toward zero, and 0x80000000 divided by 0xFFFFFFFF gives 0x80000000. DIVU (code 8) writes the unsigned quotient.
- R8: A divide with B equal to zero, or any code from 29 to 31, raises illegal_exc, holds result_we low and leaves carry, flag and overflow unchanged.
- R9: Codes 19 to 28 compare A with B and write the outcome to the flag, in this order: equal, not equal, unsigned >, >=, <, <=, then signed >, >=, <, <=. They never raise result_we, and carry and overflow are kept.
- R10: CMOV (code 17) writes A when the condition flag is 1 and B when it is 0.
- R11: MOVHI (code 12) writes B[15:0] into result bits 31:16 and zeros into bits 15:0.
- R12: Codes 13, 14, 15 and 16 sign-extend A[7:0], zero-extend A[7:0], sign-extend A[15:0] and zero-extend A[15:0] to 32 bits.
- R13: FF1 (code 18) writes the 1-based position of the lowest set bit of A, or 0 when A is zero.
- R14: Synchronous active-low reset clears carry, flag and overflow. While op_valid is low, result_we and illegal_exc stay low and the status word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation selector |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, immediate or shift amount |
| result | output | 32 | Combinational result |
| result_we | output | 1 | Result is to be written to the destination |
| illegal_exc | output | 1 | Illegal-operation strobe |
| carry_q | output | 1 | Registered carry bit |
| flag_q | output | 1 | Registered condition flag |
| ovf_q | output | 1 | Registered overflow bit |

## Verification
Directed cases cover the places where a plausible design could differ from the requirements:
- a carry-producing add, and add-with-carry with B of all ones and carry in, which tells the result-below-A carry rule apart from a true carry-out;
- the most negative number divided by minus one, and zero divisors for both divides;
- shift amounts above 31, to show that only five bits are used;
- a zero AND result, to exercise the zero-flag update;
- zero and top-bit-only inputs to the lowest-set-bit search;
- an undefined code;
- idle cycles.

Random operands over all 32 codes then follow. Divisors are forced to zero often, and operands are forced equal often enough for every compare to be seen on both outcomes. A running bench copy of the status word checks that each operation changes only the status bits it owns.

// File: rtl/alu_pkg.sv
// Shared operation encoding for the integer execution unit.
// Assumes the code space is 5 bits; codes above OP_SFLES are undefined.
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_AND   = 5'd3,
        OP_OR    = 5'd4,
        OP_XOR   = 5'd5,
        OP_MUL   = 5'd6,
        OP_DIV   = 5'd7,
        OP_DIVU  = 5'd8,
        OP_SLL   = 5'd9,
        OP_SRL   = 5'd10,
        OP_SRA   = 5'd11,
        OP_MOVHI = 5'd12,
        OP_EXTBS = 5'd13,
        OP_EXTBZ = 5'd14,
        OP_EXTHS = 5'd15,
        OP_EXTHZ = 5'd16,
        OP_CMOV  = 5'd17,
        OP_FF1   = 5'd18,
        OP_SFEQ  = 5'd19,
        OP_SFNE  = 5'd20,
        OP_SFGTU = 5'd21,
        OP_SFGEU = 5'd22,
        OP_SFLTU = 5'd23,
        OP_SFLEU = 5'd24,
        OP_SFGTS = 5'd25,
        OP_SFGES = 5'd26,
        OP_SFLTS = 5'd27,
        OP_SFLES = 5'd28
    } alu_op_e;

    // True for the ten flag-writing compare codes.
    function automatic logic op_is_compare(input logic [4:0] code);
        return (code >= OP_SFEQ) && (code <= OP_SFLES);
    endfunction

    // True for codes that have a defined meaning.
    function automatic logic op_is_known(input logic [4:0] code);
        return code <= OP_SFLES;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
// Adder and subtractor for the execution unit.
// Computes a+b+cin, or a-b when sub_sel is high. It flags a carry when
// the sum is unsigned-below operand a, and a signed overflow when the
// operands share a sign the sum does not have.
// Assumes the caller ignores carry_out when subtracting.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub_sel,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         ovf_out
);

    logic [W-1:0] b_eff;
    logic         c_eff;

    // Invert the second operand and force the carry in for subtraction.
    always_comb begin
        b_eff = sub_sel ? ~b : b;
        c_eff = sub_sel ? 1'b1 : cin;
    end

    // Sum, carry by the below-operand test, and signed overflow.
    always_comb begin
        sum       = a + b_eff + {{(W-1){1'b0}}, c_eff};
        carry_out = (sum < a);
        ovf_out   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu_shift.sv
// Barrel shifter built as log2(W) right-shift stages.
// A left shift is done by reversing the bits before and after the stages.
// Assumes arith is only raised for a right shift.
module alu_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] amt,
    input  logic          dir_left,
    input  logic          arith,
    output logic [W-1:0]  y
);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stage [0:SW];
    logic         fill;

    // Bit reversal of the input and of the last stage.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = a[W-1-i];
        assign rev_out[i] = stage[SW][W-1-i];
    end

    assign fill     = arith & a[W-1];
    assign stage[0] = dir_left ? rev_in : a;

    // One stage per amount bit, each shifting by a power of two.
    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
    end

    assign y = dir_left ? rev_out : stage[SW];

endmodule

// File: rtl/alu_cmp.sv
// Compare unit: evaluates one of ten equality or ordering predicates.
// Assumes op carries a compare code; any other code gives 0.
module alu_cmp
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic         hit
);

    // Select the predicate named by the operation code.
    always_comb begin
        case (op)
            OP_SFEQ:  hit = (a == b);
            OP_SFNE:  hit = (a != b);
            OP_SFGTU: hit = (a >  b);
            OP_SFGEU: hit = (a >= b);
            OP_SFLTU: hit = (a <  b);
            OP_SFLEU: hit = (a <= b);
            OP_SFGTS: hit = ($signed(a) >  $signed(b));
            OP_SFGES: hit = ($signed(a) >= $signed(b));
            OP_SFLTS: hit = ($signed(a) <  $signed(b));
            OP_SFLES: hit = ($signed(a) <= $signed(b));
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_div.sv
// Single-cycle divider shared by the signed and unsigned forms.
// Signed operands are reduced to magnitudes, divided unsigned, and the
// quotient is negated when the signs differ, which truncates toward zero.
// Assumes the caller discards quo when div_zero is high.
module alu_div #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         signed_mode,
    output logic [W-1:0] quo,
    output logic         div_zero
);

    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;
    logic [W-1:0] safe_b;
    logic [W-1:0] q_mag;
    logic         neg_q;

    // Magnitudes of the operands and the sign of the quotient.
    always_comb begin
        mag_a  = (signed_mode && a[W-1]) ? (~a + 1'b1) : a;
        mag_b  = (signed_mode && b[W-1]) ? (~b + 1'b1) : b;
        neg_q  = signed_mode && (a[W-1] ^ b[W-1]);
        div_zero = (b == '0);
        safe_b = div_zero ? {{(W-1){1'b0}}, 1'b1} : mag_b;
    end

    // Unsigned divide, then restore the sign.
    always_comb begin
        q_mag = mag_a / safe_b;
        quo   = neg_q ? (~q_mag + 1'b1) : q_mag;
    end

endmodule

// File: rtl/int_alu_unit.sv
// Integer execution unit with a registered carry/flag/overflow word.
// Decodes the operation, selects the result from the arithmetic, shift,
// divide and compare sub-units, and raises a strobe for illegal
// operations. The status word updates only for accepted operations.
// Assumes W is a power of two and at least 16.
module int_alu_unit
    import alu_pkg::*;
#(
    parameter int W             = 32,
    parameter bit ARITH_FLAG_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [4:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic         illegal_exc,
    output logic         carry_q,
    output logic         flag_q,
    output logic         ovf_q
);

    localparam int SW = $clog2(W);
    localparam int HW = W / 2;

    alu_op_e      op;
    logic         is_cmp;
    logic         is_known;
    logic         is_div;
    logic [W-1:0] as_sum;
    logic         as_carry;
    logic         as_ovf;
    logic [W-1:0] sh_y;
    logic [W-1:0] dv_quo;
    logic         dv_zero;
    logic         cmp_hit;
    logic [SW:0]  ff_idx;
    logic [W-1:0] and_y;
    logic         accept;

    assign op = alu_op_e'(op_code);

    // Classify the operation code.
    always_comb begin
        is_cmp   = op_is_compare(op_code);
        is_known = op_is_known(op_code);
        is_div   = (op == OP_DIV) || (op == OP_DIVU);
    end

    alu_addsub #(.W(W)) u_addsub (
        .a         (opnd_a),
        .b         (opnd_b),
        .cin       ((op == OP_ADDC) ? carry_q : 1'b0),
        .sub_sel   (op == OP_SUB),
        .sum       (as_sum),
        .carry_out (as_carry),
        .ovf_out   (as_ovf)
    );

    alu_shift #(.W(W), .SW(SW)) u_shift (
        .a        (opnd_a),
        .amt      (opnd_b[SW-1:0]),
        .dir_left (op == OP_SLL),
        .arith    (op == OP_SRA),
        .y        (sh_y)
    );

    alu_div #(.W(W)) u_div (
        .a           (opnd_a),
        .b           (opnd_b),
        .signed_mode (op == OP_DIV),
        .quo         (dv_quo),
        .div_zero    (dv_zero)
    );

    alu_cmp #(.W(W)) u_cmp (
        .a   (opnd_a),
        .b   (opnd_b),
        .op  (op),
        .hit (cmp_hit)
    );

    // Position of the lowest set bit, counted from 1.
    always_comb begin
        ff_idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (opnd_a[i]) ff_idx = (SW + 1)'(i + 1);
        end
    end

    assign and_y = opnd_a & opnd_b;

    // Write enable and exception strobe.
    always_comb begin
        illegal_exc = op_valid && (!is_known || (is_div && dv_zero));
        result_we   = op_valid && is_known && !is_cmp && !(is_div && dv_zero);
        accept      = op_valid && !illegal_exc;
    end

    // Result selection.
    always_comb begin
        case (op)
            OP_ADD, OP_ADDC, OP_SUB: result = as_sum;
            OP_AND:   result = and_y;
            OP_OR:    result = opnd_a | opnd_b;
            OP_XOR:   result = opnd_a ^ opnd_b;
            OP_MUL:   result = opnd_a * opnd_b;
            OP_DIV, OP_DIVU: result = dv_quo;
            OP_SLL, OP_SRL, OP_SRA: result = sh_y;
            OP_MOVHI: result = {opnd_b[HW-1:0], {HW{1'b0}}};
            OP_EXTBS: result = {{(W-8){opnd_a[7]}}, opnd_a[7:0]};
            OP_EXTBZ: result = {{(W-8){1'b0}}, opnd_a[7:0]};
            OP_EXTHS: result = {{(W-16){opnd_a[15]}}, opnd_a[15:0]};
            OP_EXTHZ: result = {{(W-16){1'b0}}, opnd_a[15:0]};
            OP_CMOV:  result = flag_q ? opnd_a : opnd_b;
            OP_FF1:   result = {{(W-SW-1){1'b0}}, ff_idx};
            default:  result = '0;
        endcase
    end

    // Status word: each accepted operation updates only the bits it owns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            flag_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (accept) begin
            case (op)
                OP_ADD, OP_ADDC: begin
                    carry_q <= as_carry;
                    ovf_q   <= as_ovf;
                    if (ARITH_FLAG_EN) flag_q <= (as_sum == '0);
                end
                OP_SUB: ovf_q <= as_ovf;
                OP_AND: if (ARITH_FLAG_EN) flag_q <= (and_y == '0);
                default: if (is_cmp) flag_q <= cmp_hit;
            endcase
        end
    end

    // R8: a zero divisor traps and suppresses the write.
    p_div_zero_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 5'd7 || op_code == 5'd8) && opnd_b == '0)
        |-> (illegal_exc && !result_we));

    // R8: a trapped operation leaves the status word untouched.
    p_trap_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_exc |=> ($stable(carry_q) && $stable(flag_q) && $stable(ovf_q)));

    // R9: compares never request a result write.
    p_cmp_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 5'd19 && op_code <= 5'd28) |-> (!result_we && !illegal_exc));

    // R3: only the two add forms may move the carry bit.
    p_carry_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code != 5'd0 && op_code != 5'd1) |=> $stable(carry_q));

    // R14: idle cycles hold the status word and assert no strobe.
    p_idle_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!result_we && !illegal_exc));
    p_idle_status_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(carry_q) && $stable(flag_q) && $stable(ovf_q)));

endmodule

// File: tb/int_alu_unit_test.sv
`timescale 1ns/1ps
module int_alu_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = 5'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        result_we;
    logic        illegal_exc;
    logic        carry_q;
    logic        flag_q;
    logic        ovf_q;

    int checks = 0;
    int errors = 0;
    logic m_c = 0, m_f = 0, m_v = 0;

    always #10 clk = ~clk;

    int_alu_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .result_we(result_we),
        .illegal_exc(illegal_exc), .carry_q(carry_q), .flag_q(flag_q), .ovf_q(ovf_q)
    );

    function automatic string req_of(input logic [4:0] oc);
        case (oc)
            0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
            4, 5, 6: return "R5";  7, 8: return "R7";  9, 10, 11: return "R6";
            12: return "R11"; 13, 14, 15, 16: return "R12"; 17: return "R10";
            18: return "R13";
            default: return (oc >= 19 && oc <= 28) ? "R9" : "R8";
        endcase
    endfunction

    function automatic logic fits32(input longint v);
        return (v <= 64'sd2147483647) && (v >= -64'sd2147483648);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [4:0] oc, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r; logic we, ex; logic nc, nf, nv; longint sl; string rq;
        r = 0; we = 1; ex = 0; nc = m_c; nf = m_f; nv = m_v; rq = req_of(oc);
        case (oc)
            0, 1: begin
                r  = a + b + ((oc == 1) ? {31'd0, m_c} : 32'd0);
                nc = (r < a);
                sl = longint'($signed(a)) + longint'($signed(b)) + ((oc == 1) ? longint'(m_c) : 0);
                nv = !fits32(sl); nf = (r == 0);
            end
            2: begin r = a - b; sl = longint'($signed(a)) - longint'($signed(b)); nv = !fits32(sl); end
            3: begin r = a & b; nf = (r == 0); end
            4: r = a | b;
            5: r = a ^ b;
            6: r = a * b;
            7: if (b == 0) begin we = 0; ex = 1; end
               else r = 32'(longint'($signed(a)) / longint'($signed(b)));
            8: if (b == 0) begin we = 0; ex = 1; end else r = a / b;
            9:  r = a << b[4:0];
            10: r = a >> b[4:0];
            11: r = 32'($signed(a) >>> b[4:0]);
            12: r = {b[15:0], 16'h0000};
            13: r = {{24{a[7]}}, a[7:0]};
            14: r = {24'h0, a[7:0]};
            15: r = {{16{a[15]}}, a[15:0]};
            16: r = {16'h0, a[15:0]};
            17: r = m_f ? a : b;
            18: begin r = 0; for (int i = 0; i < 32; i++) if (a[i] && r == 0) r = i + 1; end
            19: begin we = 0; nf = (a == b); end
            20: begin we = 0; nf = (a != b); end
            21: begin we = 0; nf = (a > b); end
            22: begin we = 0; nf = (a >= b); end
            23: begin we = 0; nf = (a < b); end
            24: begin we = 0; nf = (a <= b); end
            25: begin we = 0; nf = ($signed(a) > $signed(b)); end
            26: begin we = 0; nf = ($signed(a) >= $signed(b)); end
            27: begin we = 0; nf = ($signed(a) < $signed(b)); end
            28: begin we = 0; nf = ($signed(a) <= $signed(b)); end
            default: begin we = 0; ex = 1; end
        endcase
        @(negedge clk);
        op_valid = 1; op_code = oc; opnd_a = a; opnd_b = b;
        #2;
        check(rq, "result_we", {31'd0, result_we}, {31'd0, we});
        check(rq, "illegal_exc", {31'd0, illegal_exc}, {31'd0, ex});
        if (we) check(rq, $sformatf("result op%0d", oc), result, r);
        @(posedge clk); #2;
        op_valid = 0;
        m_c = nc; m_f = nf; m_v = nv;
        check(rq, "carry_q", {31'd0, carry_q}, {31'd0, m_c});
        check(rq, "flag_q", {31'd0, flag_q}, {31'd0, m_f});
        check(rq, "ovf_q", {31'd0, ovf_q}, {31'd0, m_v});
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [4:0] oc; logic [31:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #2;
        // R14: reset state
        check("R14", "reset carry", {31'd0, carry_q}, 0);
        check("R14", "reset flag", {31'd0, flag_q}, 0);
        check("R14", "reset ovf", {31'd0, ovf_q}, 0);
        // R1: carry and signed overflow
        run_op(0, 32'hFFFF_FFFF, 32'h0000_0002);
        run_op(0, 32'h7FFF_FFFF, 32'h0000_0001);
        // R2: all-ones plus carry keeps carry clear; result equals A
        run_op(0, 32'hFFFF_FFFF, 32'h0000_0001);
        run_op(1, 32'h1234_5678, 32'hFFFF_FFFF);
        check("R2", "carry after a+~0+1", {31'd0, carry_q}, 0);
        run_op(1, 32'h0000_0010, 32'h0000_0020);
        // R3 / R4: sub leaves carry, AND zero sets flag
        run_op(0, 32'h8000_0000, 32'h8000_0000);
        run_op(2, 32'h8000_0000, 32'h0000_0001);
        run_op(3, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
        run_op(4, 32'h0000_0000, 32'h0000_0000);
        // R7 / R8: divides
        run_op(7, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op(7, 32'hFFFF_FFF9, 32'h0000_0002);
        run_op(7, 32'h0000_0005, 32'h0000_0000);
        run_op(8, 32'hFFFF_FFFF, 32'h0000_0000);
        run_op(8, 32'hFFFF_FFFF, 32'h0000_0010);
        run_op(30, 32'h1, 32'h1);
        // R6: shift amount beyond 31
        run_op(9, 32'h0000_0001, 32'h0000_0021);
        run_op(11, 32'h8000_0000, 32'h0000_003F);
        run_op(10, 32'h8000_0000, 32'h0000_001F);
        // R13: lowest set bit
        run_op(18, 32'h0, 32'h0);
        run_op(18, 32'h8000_0000, 32'h0);
        // R9 / R10: compare then select on both outcomes
        run_op(27, 32'hFFFF_FFFF, 32'h0000_0001);
        run_op(17, 32'hAAAA_AAAA, 32'h5555_5555);
        run_op(23, 32'hFFFF_FFFF, 32'h0000_0001);
        run_op(17, 32'hAAAA_AAAA, 32'h5555_5555);
        // R11 / R12
        run_op(12, 32'hDEAD_BEEF, 32'h0001_ABCD);
        run_op(13, 32'h0000_0080, 32'h0);
        run_op(15, 32'h0000_8001, 32'h0);
        // R14: idle cycle keeps status and strobes low
        @(negedge clk); op_valid = 0; op_code = 5'd19; opnd_a = 1; opnd_b = 2;
        #2;
        check("R14", "idle result_we", {31'd0, result_we}, 0);
        check("R14", "idle illegal_exc", {31'd0, illegal_exc}, 0);
        @(posedge clk); #2;
        check("R14", "idle flag", {31'd0, flag_q}, {31'd0, m_f});
        check("R14", "idle carry", {31'd0, carry_q}, {31'd0, m_c});
        // Random mix over all codes
        for (int n = 0; n < 4000; n++) begin
            oc = 5'($urandom_range(0, 31));
            a = $urandom; b = $urandom;
            case ($urandom_range(0, 7))
                0: b = 0;
                1: b = a;
                2: a = 32'h8000_0000;
                default: ;
            endcase
            run_op(oc, a, b);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule